// File: doc/BRIEF.md
# Set-Associative Instruction Address Translator

This block turns instruction-fetch virtual addresses into physical addresses. It holds two register arrays organised as sets by ways. A match word per entry carries the virtual tag, a valid flag and a small age counter that ranks recent use. A translate word per entry carries the physical page number, a cache-inhibit flag and separate execute permissions for user and supervisor code. Each fetch request is classified and the result is registered. The result is a translated address, a bypassed address when translation is off, a miss, or a permission fault. The block never refills itself. Software loads both arrays through a word-wide register access port, and a miss or fault is only reported to whoever handles the exception.

A second lookup path, the probe port, runs the same search on an independent address. It does not age any entry and raises no indication. It lets a debugger or a software walker find out where an address would land without disturbing the block.

The result logic is a five-state machine that is reloaded every cycle. The states are ST_IDLE (no request last cycle), ST_BYPASS (translation off or not present), ST_HIT (tag hit with execute permission), ST_MISS (no valid way matched) and ST_FAULT (tag hit without the required execute permission). The transition into each state is taken from the request sampled at the clock edge. A request that is not present leads to ST_IDLE. With translation inactive it leads to ST_BYPASS. With no matching way it leads to ST_MISS. A hit whose permission is missing leads to ST_FAULT, and any other hit leads to ST_HIT. Every state can move to any other in the next cycle.

Top module: `itlb_xlate`

## Requirements
- R1: When `xlate_en` or `mmu_present` is low, a fetch returns `rsp_pa` equal to `fetch_va`, and `rsp_ci` equals the top address bit (set for addresses at or above 0x80000000). `rsp_hit`, `rsp_miss` and `rsp_fault` all stay low.
- R2: The set index is `fetch_va[15:13]` (page offset bits 12:0, 8 sets). A way hits only if bit 0 (valid) of its match word is set and match word bits 31:16 equal `fetch_va[31:16]`.
- R3: On a permitted hit, `rsp_hit` pulses and `rsp_pa` is translate-word bits 31:13 followed by `fetch_va[12:0]`. `rsp_ci` is translate-word bit 0.
- R4: The age field is match-word bits 2:1. A tag hit sets the hit way's age to USTATES-1 (3 by default). Every other way of that set with a nonzero age loses one, and a zero age stays zero.
- R5: On a tag hit, supervisor mode needs translate bit 2 and user mode needs translate bit 1. If the needed bit is clear, `rsp_fault` pulses, `rsp_pa` is 0, `rsp_va` holds the fetch address, and the ages are still updated as in R4.
- R6: On a miss, `rsp_miss` pulses, `rsp_pa` is 0 and `rsp_va` holds the fetch address. No array word changes.
- R7: If several valid ways of a set match, the way with the highest index supplies the translation.
- R8: `probe_pa` and `probe_ci` show, one cycle after `probe_va`, the same lookup result. A miss or a permission failure gives 0 and 0, and inactive translation gives `probe_va` and its top bit. A probe never changes an age.
- R9: `cfg_we` writes `cfg_wdata` into the word picked by `cfg_sel_trans` (0 selects the match array, 1 the translate array), `cfg_set` and `cfg_way`. `cfg_rdata` shows the selected word one cycle after the selection is presented.
- R10: Every fetch request gives exactly one `rsp_valid` cycle, in the cycle after the request. No response appears without a request, and back-to-back requests give back-to-back responses.
- R11: A register write in the same cycle as a fetch takes effect, and that fetch's age update is dropped. The fetch itself is looked up in the table as it stood before the write.
- R12: After reset every array word is 0 and `rsp_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| fetch_req | input | 1 | Fetch lookup request |
| fetch_va | input | 32 | Fetch virtual address |
| xlate_en | input | 1 | Translation enable |
| mmu_present | input | 1 | Translation unit implemented |
| sup_mode | input | 1 | Fetch runs in supervisor mode |
| rsp_valid | output | 1 | Result strobe |
| rsp_pa | output | 32 | Physical address, 0 on miss or fault |
| rsp_ci | output | 1 | Cache-inhibit for the fetch |
| rsp_hit | output | 1 | Permitted hit pulse |
| rsp_miss | output | 1 | Miss pulse |
| rsp_fault | output | 1 | Execute permission fault pulse |
| rsp_va | output | 32 | Virtual address of the answered request |
| probe_va | input | 32 | Probe virtual address |
| probe_pa | output | 32 | Probe result address |
| probe_ci | output | 1 | Probe cache-inhibit |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel_trans | input | 1 | 0 = match array, 1 = translate array |
| cfg_set | input | 3 | Register set index |
| cfg_way | input | 2 | Register way index |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data |

## Verification
A fetch result is due in the cycle after the request edge. The bench therefore pushes its predicted result into a queue when it drives the request, and pops and compares at the next falling edge. Responses left in the queue at the end, or a response with nothing queued, count as errors. The probe result and the read-back word also have one register of latency, so each is sampled one full cycle after its address is set. Age effects are checked by reading match words back after the fetch edge. The model's ages are advanced at push time, and the read-back is sampled after the write has landed.

// File: rtl/itlb_pkg.sv
package itlb_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_BYPASS,
        ST_HIT,
        ST_MISS,
        ST_FAULT
    } itlb_state_e;

    // match word fields
    localparam int unsigned VALID_BIT = 0;
    localparam int unsigned AGE_LSB   = 1;
    localparam int unsigned AGE_W     = 2;
    // translate word fields
    localparam int unsigned CI_BIT    = 0;
    localparam int unsigned UXE_BIT   = 1;
    localparam int unsigned SXE_BIT   = 2;

endpackage

// File: rtl/itlb_match.sv
module itlb_match
    import itlb_pkg::*;
#(
    parameter int unsigned VA_W      = 32,
    parameter int unsigned PAGE_BITS = 13,
    parameter int unsigned WAYS      = 4,
    parameter int unsigned TAG_LSB   = 16
) (
    input  logic [VA_W-1:TAG_LSB]        va_tag,
    input  logic [PAGE_BITS-1:0]         va_off,
    input  logic [WAYS-1:0][VA_W-1:0]    mrow,
    input  logic [WAYS-1:0][VA_W-1:0]    trow,
    output logic [WAYS-1:0]              hit_oh,
    output logic [VA_W-1:0]              pa,
    output logic                         ci,
    output logic                         uxe,
    output logic                         sxe
);

    logic [WAYS-1:0]   raw_match;
    logic [VA_W-1:0]   sel_t;
    logic [WAYS-1:0]   unused_w;

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        assign raw_match[w] = mrow[w][VALID_BIT] &&
                              (mrow[w][VA_W-1:TAG_LSB] == va_tag);
        assign unused_w[w]  = ^mrow[w][TAG_LSB-1:1];
    end

    // highest matching way wins
    always_comb begin
        logic taken;
        taken  = 1'b0;
        hit_oh = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (raw_match[w] && !taken) begin
                hit_oh[w] = 1'b1;
                taken     = 1'b1;
            end
        end
    end

    always_comb begin
        sel_t = '0;
        for (int w = 0; w < WAYS; w++) begin
            sel_t = sel_t | (trow[w] & {VA_W{hit_oh[w]}});
        end
    end

    logic unused_sel;
    assign unused_sel = ^{sel_t[PAGE_BITS-1:SXE_BIT+1], unused_w};

    assign pa  = {sel_t[VA_W-1:PAGE_BITS], va_off};
    assign ci  = sel_t[CI_BIT];
    assign uxe = sel_t[UXE_BIT];
    assign sxe = sel_t[SXE_BIT];

endmodule

// File: rtl/itlb_store.sv
module itlb_store
    import itlb_pkg::*;
#(
    parameter int unsigned VA_W     = 32,
    parameter int unsigned SETS     = 8,
    parameter int unsigned WAYS     = 4,
    parameter int unsigned USTATES  = 4,
    parameter int unsigned SET_BITS = 3,
    parameter int unsigned WAY_BITS = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cfg_we,
    input  logic                         cfg_sel_trans,
    input  logic [SET_BITS-1:0]          cfg_set,
    input  logic [WAY_BITS-1:0]          cfg_way,
    input  logic [VA_W-1:0]              cfg_wdata,
    output logic [VA_W-1:0]              cfg_rdata,
    input  logic [SET_BITS-1:0]          fetch_set,
    input  logic [SET_BITS-1:0]          probe_set,
    output logic [WAYS-1:0][VA_W-1:0]    f_mrow,
    output logic [WAYS-1:0][VA_W-1:0]    f_trow,
    output logic [WAYS-1:0][VA_W-1:0]    p_mrow,
    output logic [WAYS-1:0][VA_W-1:0]    p_trow,
    input  logic                         upd_en,
    input  logic [SET_BITS-1:0]          upd_set,
    input  logic [WAYS-1:0]              upd_oh
);

    localparam logic [AGE_W-1:0] AGE_TOP = AGE_W'(USTATES - 1);

    logic [SETS-1:0][WAYS-1:0][VA_W-1:0] m_q;
    logic [SETS-1:0][WAYS-1:0][VA_W-1:0] t_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_q <= '0;
            t_q <= '0;
        end else begin
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    if (cfg_we && !cfg_sel_trans &&
                        cfg_set == SET_BITS'(s) && cfg_way == WAY_BITS'(w)) begin
                        m_q[s][w] <= cfg_wdata;
                    end else if (upd_en && !cfg_we && upd_set == SET_BITS'(s)) begin
                        if (upd_oh[w]) begin
                            m_q[s][w][AGE_LSB +: AGE_W] <= AGE_TOP;
                        end else if (m_q[s][w][AGE_LSB +: AGE_W] != '0) begin
                            m_q[s][w][AGE_LSB +: AGE_W] <= m_q[s][w][AGE_LSB +: AGE_W] - 1'b1;
                        end
                    end
                    if (cfg_we && cfg_sel_trans &&
                        cfg_set == SET_BITS'(s) && cfg_way == WAY_BITS'(w)) begin
                        t_q[s][w] <= cfg_wdata;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_rdata <= '0;
        end else if (cfg_sel_trans) begin
            cfg_rdata <= t_q[cfg_set][cfg_way];
        end else begin
            cfg_rdata <= m_q[cfg_set][cfg_way];
        end
    end

    assign f_mrow = m_q[fetch_set];
    assign f_trow = t_q[fetch_set];
    assign p_mrow = m_q[probe_set];
    assign p_trow = t_q[probe_set];

    // checker state for the age refresh
    logic                chk_upd_q;
    logic [SET_BITS-1:0] chk_set_q;
    logic [WAYS-1:0]     chk_oh_q;
    logic                hit_age_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chk_upd_q <= 1'b0;
            chk_set_q <= '0;
            chk_oh_q  <= '0;
        end else begin
            chk_upd_q <= upd_en && !cfg_we;
            chk_set_q <= upd_set;
            chk_oh_q  <= upd_oh;
        end
    end

    always_comb begin
        hit_age_ok = 1'b1;
        for (int w = 0; w < WAYS; w++) begin
            if (chk_oh_q[w] && m_q[chk_set_q][w][AGE_LSB +: AGE_W] != AGE_TOP) begin
                hit_age_ok = 1'b0;
            end
        end
    end

    // R4
    hit_age_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chk_upd_q |-> hit_age_ok);

    // R6
    table_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd_en && !cfg_we) |=> $stable(m_q) && $stable(t_q));

endmodule

// File: rtl/itlb_xlate.sv
module itlb_xlate
    import itlb_pkg::*;
#(
    parameter int unsigned VA_W      = 32,
    parameter int unsigned PAGE_BITS = 13,
    parameter int unsigned SETS      = 8,
    parameter int unsigned WAYS      = 4,
    parameter int unsigned USTATES   = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 fetch_req,
    input  logic [VA_W-1:0]      fetch_va,
    input  logic                 xlate_en,
    input  logic                 mmu_present,
    input  logic                 sup_mode,
    output logic                 rsp_valid,
    output logic [VA_W-1:0]      rsp_pa,
    output logic                 rsp_ci,
    output logic                 rsp_hit,
    output logic                 rsp_miss,
    output logic                 rsp_fault,
    output logic [VA_W-1:0]      rsp_va,
    input  logic [VA_W-1:0]      probe_va,
    output logic [VA_W-1:0]      probe_pa,
    output logic                 probe_ci,
    input  logic                 cfg_we,
    input  logic                 cfg_sel_trans,
    input  logic [$clog2(SETS)-1:0] cfg_set,
    input  logic [((WAYS > 1) ? $clog2(WAYS) : 1)-1:0] cfg_way,
    input  logic [VA_W-1:0]      cfg_wdata,
    output logic [VA_W-1:0]      cfg_rdata
);

    localparam int unsigned SET_BITS = $clog2(SETS);
    localparam int unsigned WAY_BITS = (WAYS > 1) ? $clog2(WAYS) : 1;
    localparam int unsigned TAG_LSB  = PAGE_BITS + SET_BITS;

    logic                      active;
    logic [SET_BITS-1:0]       f_set;
    logic [SET_BITS-1:0]       p_set;
    logic [WAYS-1:0][VA_W-1:0] f_mrow, f_trow, p_mrow, p_trow;
    logic [WAYS-1:0]           f_oh, p_oh;
    logic [VA_W-1:0]           f_pa, p_pa;
    logic                      f_ci, f_uxe, f_sxe;
    logic                      p_ci, p_uxe, p_sxe;
    logic                      f_hit, p_hit, f_perm, p_perm;

    assign active = xlate_en && mmu_present;
    assign f_set  = fetch_va[TAG_LSB-1:PAGE_BITS];
    assign p_set  = probe_va[TAG_LSB-1:PAGE_BITS];

    itlb_store #(
        .VA_W(VA_W), .SETS(SETS), .WAYS(WAYS), .USTATES(USTATES),
        .SET_BITS(SET_BITS), .WAY_BITS(WAY_BITS)
    ) store_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_sel_trans(cfg_sel_trans),
        .cfg_set(cfg_set), .cfg_way(cfg_way),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .fetch_set(f_set), .probe_set(p_set),
        .f_mrow(f_mrow), .f_trow(f_trow),
        .p_mrow(p_mrow), .p_trow(p_trow),
        .upd_en(fetch_req && active && f_hit),
        .upd_set(f_set), .upd_oh(f_oh)
    );

    itlb_match #(
        .VA_W(VA_W), .PAGE_BITS(PAGE_BITS), .WAYS(WAYS), .TAG_LSB(TAG_LSB)
    ) fmatch_i (
        .va_tag(fetch_va[VA_W-1:TAG_LSB]), .va_off(fetch_va[PAGE_BITS-1:0]),
        .mrow(f_mrow), .trow(f_trow), .hit_oh(f_oh),
        .pa(f_pa), .ci(f_ci), .uxe(f_uxe), .sxe(f_sxe)
    );

    itlb_match #(
        .VA_W(VA_W), .PAGE_BITS(PAGE_BITS), .WAYS(WAYS), .TAG_LSB(TAG_LSB)
    ) pmatch_i (
        .va_tag(probe_va[VA_W-1:TAG_LSB]), .va_off(probe_va[PAGE_BITS-1:0]),
        .mrow(p_mrow), .trow(p_trow), .hit_oh(p_oh),
        .pa(p_pa), .ci(p_ci), .uxe(p_uxe), .sxe(p_sxe)
    );

    assign f_hit  = |f_oh;
    assign p_hit  = |p_oh;
    assign f_perm = sup_mode ? f_sxe : f_uxe;
    assign p_perm = sup_mode ? p_sxe : p_uxe;

    // ---------------- result state machine ----------------
    itlb_state_e state_q, state_d;

    always_comb begin
        if (!fetch_req) begin
            state_d = ST_IDLE;
        end else if (!active) begin
            state_d = ST_BYPASS;
        end else if (!f_hit) begin
            state_d = ST_MISS;
        end else if (!f_perm) begin
            state_d = ST_FAULT;
        end else begin
            state_d = ST_HIT;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    logic [VA_W-1:0] pa_q, va_q;
    logic            ci_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pa_q <= '0;
            ci_q <= 1'b0;
            va_q <= '0;
        end else if (fetch_req) begin
            va_q <= fetch_va;
            unique case (state_d)
                ST_BYPASS: begin
                    pa_q <= fetch_va;
                    ci_q <= fetch_va[VA_W-1];
                end
                ST_HIT: begin
                    pa_q <= f_pa;
                    ci_q <= f_ci;
                end
                default: begin
                    pa_q <= '0;
                    ci_q <= 1'b0;
                end
            endcase
        end
    end

    always_comb begin
        rsp_valid = 1'b0;
        rsp_hit   = 1'b0;
        rsp_miss  = 1'b0;
        rsp_fault = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_BYPASS: rsp_valid = 1'b1;
            ST_HIT: begin
                rsp_valid = 1'b1;
                rsp_hit   = 1'b1;
            end
            ST_MISS: begin
                rsp_valid = 1'b1;
                rsp_miss  = 1'b1;
            end
            ST_FAULT: begin
                rsp_valid = 1'b1;
                rsp_fault = 1'b1;
            end
        endcase
    end

    assign rsp_pa = pa_q;
    assign rsp_ci = ci_q;
    assign rsp_va = va_q;

    // ---------------- probe path ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            probe_pa <= '0;
            probe_ci <= 1'b0;
        end else if (!active) begin
            probe_pa <= probe_va;
            probe_ci <= probe_va[VA_W-1];
        end else if (p_hit && p_perm) begin
            probe_pa <= p_pa;
            probe_ci <= p_ci;
        end else begin
            probe_pa <= '0;
            probe_ci <= 1'b0;
        end
    end

    // ---------------- assertions ----------------
    // R10
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req |=> rsp_valid);

    // R10
    no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_req |=> !rsp_valid);

    // R1
    bypass_identity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req && !active) |=> (rsp_pa == $past(fetch_va)) &&
            (rsp_ci == $past(fetch_va[VA_W-1])) && !rsp_hit && !rsp_miss && !rsp_fault);

    // R6
    miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_miss |-> (rsp_pa == '0) && !rsp_ci);

    // R5
    fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> (rsp_pa == '0) && !rsp_hit);

    // R8
    probe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (probe_pa == $past(probe_va)));

endmodule

// File: tb/itlb_xlate_tb_top.sv
`timescale 1ns/100ps
module itlb_xlate_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fetch_req = 1'b0;
    logic [31:0] fetch_va = '0;
    logic        xlate_en = 1'b0;
    logic        mmu_present = 1'b0;
    logic        sup_mode = 1'b0;
    logic        rsp_valid, rsp_ci, rsp_hit, rsp_miss, rsp_fault;
    logic [31:0] rsp_pa, rsp_va;
    logic [31:0] probe_va = '0;
    logic [31:0] probe_pa;
    logic        probe_ci;
    logic        cfg_we = 1'b0;
    logic        cfg_sel_trans = 1'b0;
    logic [2:0]  cfg_set = '0;
    logic [1:0]  cfg_way = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;

    always #2.5 clk = ~clk;

    itlb_xlate dut_i (
        .clk(clk), .rst_n(rst_n),
        .fetch_req(fetch_req), .fetch_va(fetch_va),
        .xlate_en(xlate_en), .mmu_present(mmu_present), .sup_mode(sup_mode),
        .rsp_valid(rsp_valid), .rsp_pa(rsp_pa), .rsp_ci(rsp_ci),
        .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_fault(rsp_fault),
        .rsp_va(rsp_va),
        .probe_va(probe_va), .probe_pa(probe_pa), .probe_ci(probe_ci),
        .cfg_we(cfg_we), .cfg_sel_trans(cfg_sel_trans),
        .cfg_set(cfg_set), .cfg_way(cfg_way),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata)
    );

    // kind: 0 bypass, 1 hit, 2 miss, 3 fault
    typedef struct {
        logic [31:0] pa;
        logic        ci;
        int          kind;
        logic [31:0] va;
        string       req;
    } exp_t;

    exp_t        sb_q[$];
    int          checks = 0;
    int          errors = 0;
    logic [31:0] bm [8][4];
    logic [31:0] bt [8][4];

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // reference model built from the requirements
    function automatic exp_t model(input logic [31:0] va, input logic en,
                                   input logic impl, input logic sup,
                                   input bit upd, input string req);
        exp_t e;
        int s, way;
        e.va = va; e.req = req; e.pa = '0; e.ci = 1'b0;
        if (!(en && impl)) begin
            e.kind = 0; e.pa = va; e.ci = va[31];
            return e;
        end
        s = int'(va[15:13]);
        way = -1;
        for (int w = 0; w < 4; w++)
            if (bm[s][w][0] && bm[s][w][31:16] == va[31:16]) way = w;
        if (way < 0) begin
            e.kind = 2;
            return e;
        end
        if (upd) begin
            for (int w = 0; w < 4; w++) begin
                if (w == way) bm[s][w][2:1] = 2'd3;
                else if (bm[s][w][2:1] != 2'd0) bm[s][w][2:1] = bm[s][w][2:1] - 2'd1;
            end
        end
        if (!(sup ? bt[s][way][2] : bt[s][way][1])) begin
            e.kind = 3;
            return e;
        end
        e.kind = 1;
        e.pa = {bt[s][way][31:13], va[12:0]};
        e.ci = bt[s][way][0];
        return e;
    endfunction

    // monitor: result due one cycle after request
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "R10", "response without request", 32'd1, 32'd0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                check(rsp_pa == e.pa, e.req, "rsp_pa", rsp_pa, e.pa);
                check(rsp_ci == e.ci, e.req, "rsp_ci", {31'd0, rsp_ci}, {31'd0, e.ci});
                check({rsp_fault, rsp_miss, rsp_hit} ==
                      {e.kind == 3, e.kind == 2, e.kind == 1}, e.req, "flags {fault,miss,hit}",
                      {29'd0, rsp_fault, rsp_miss, rsp_hit},
                      {29'd0, e.kind == 3, e.kind == 2, e.kind == 1});
                if (e.kind >= 2)
                    check(rsp_va == e.va, e.req, "rsp_va", rsp_va, e.va);
            end
        end
    end

    task automatic fetch(input logic [31:0] va, input logic en, input logic impl,
                         input logic sup, input string req);
        @(negedge clk);
        fetch_req = 1'b1; fetch_va = va;
        xlate_en = en; mmu_present = impl; sup_mode = sup;
        sb_q.push_back(model(va, en, impl, sup, 1'b1, req));
        @(posedge clk); #1;
        fetch_req = 1'b0;
    endtask

    task automatic cfg_wr(input logic tr, input int s, input int w, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel_trans = tr; cfg_set = 3'(s); cfg_way = 2'(w); cfg_wdata = d;
        if (tr) bt[s][w] = d; else bm[s][w] = d;
        @(posedge clk); #1;
        cfg_we = 1'b0;
    endtask

    task automatic cfg_rd(input logic tr, input int s, input int w, input string req);
        logic [31:0] exp;
        @(negedge clk);
        cfg_sel_trans = tr; cfg_set = 3'(s); cfg_way = 2'(w);
        @(negedge clk);
        exp = tr ? bt[s][w] : bm[s][w];
        check(cfg_rdata == exp, req, "cfg_rdata", cfg_rdata, exp);
    endtask

    task automatic probe(input logic [31:0] va, input logic en, input logic sup,
                         input string req);
        exp_t e;
        logic [31:0] epa;
        logic eci;
        @(negedge clk);
        probe_va = va; xlate_en = en; mmu_present = 1'b1; sup_mode = sup;
        @(negedge clk);
        e = model(va, en, 1'b1, sup, 1'b0, req);
        epa = (e.kind == 0 || e.kind == 1) ? e.pa : 32'd0;
        eci = (e.kind == 0 || e.kind == 1) ? e.ci : 1'b0;
        check(probe_pa == epa, req, "probe_pa", probe_pa, epa);
        check(probe_ci == eci, req, "probe_ci", {31'd0, probe_ci}, {31'd0, eci});
    endtask

    bit finished = 1'b0;

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            check(1'b0, "R10", "watchdog expired", 32'd0, 32'd1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int s = 0; s < 8; s++)
            for (int w = 0; w < 4; w++) begin
                bm[s][w] = '0;
                bt[s][w] = '0;
            end
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;

        // R12 reset state
        @(negedge clk);
        check(rsp_valid == 1'b0, "R12", "rsp_valid after reset", {31'd0, rsp_valid}, 32'd0);
        cfg_rd(1'b0, 0, 0, "R12");
        cfg_rd(1'b1, 7, 3, "R12");

        // R1 bypass, back-to-back (R10)
        fetch(32'h0000_1234, 1'b0, 1'b1, 1'b0, "R1");
        fetch(32'h8000_0010, 1'b1, 1'b0, 1'b0, "R1");
        fetch(32'h7FFF_FFFC, 1'b0, 1'b0, 1'b1, "R1");
        fetch(32'h8000_0000, 1'b0, 1'b1, 1'b0, "R1");

        // load set 2
        cfg_wr(1'b0, 2, 1, 32'h1234_0001);
        cfg_wr(1'b1, 2, 1, 32'h0ABC_E007);
        cfg_wr(1'b0, 2, 0, 32'h5555_0005);
        cfg_wr(1'b0, 2, 3, 32'h0000_0002);
        cfg_wr(1'b0, 2, 2, 32'h1234_0000);   // same tag, not valid: R2
        cfg_rd(1'b1, 2, 1, "R9");
        cfg_rd(1'b0, 2, 0, "R9");

        // R3 hit, R4 ages
        fetch(32'h1234_4567, 1'b1, 1'b1, 1'b0, "R3");
        cfg_rd(1'b0, 2, 1, "R4");
        cfg_rd(1'b0, 2, 0, "R4");
        cfg_rd(1'b0, 2, 3, "R4");
        cfg_rd(1'b0, 2, 2, "R4");
        fetch(32'h1234_5FFF, 1'b1, 1'b1, 1'b1, "R3");
        cfg_rd(1'b0, 2, 0, "R4");
        cfg_rd(1'b0, 2, 3, "R4");

        // R2 same tag, other set -> miss (R6), table unchanged
        fetch(32'h1234_6000, 1'b1, 1'b1, 1'b0, "R2");
        fetch(32'hDEAD_4000, 1'b1, 1'b1, 1'b0, "R6");
        cfg_rd(1'b0, 2, 1, "R6");
        cfg_rd(1'b0, 2, 0, "R6");

        // R5 permissions
        cfg_wr(1'b0, 5, 0, 32'h00AB_0001);
        cfg_wr(1'b1, 5, 0, 32'h0040_2004);
        fetch(32'h00AB_A010, 1'b1, 1'b1, 1'b0, "R5");
        cfg_rd(1'b0, 5, 0, "R5");
        fetch(32'h00AB_A010, 1'b1, 1'b1, 1'b1, "R5");

        // R7 multiple match, highest way
        cfg_wr(1'b0, 5, 3, 32'h00AB_0001);
        cfg_wr(1'b1, 5, 3, 32'h0777_E006);
        fetch(32'h00AB_A123, 1'b1, 1'b1, 1'b0, "R7");
        cfg_rd(1'b0, 5, 3, "R7");

        // R8 probe
        probe(32'h1234_4567, 1'b1, 1'b0, "R8");
        cfg_rd(1'b0, 2, 1, "R8");
        cfg_rd(1'b0, 2, 0, "R8");
        probe(32'h9999_0000, 1'b1, 1'b0, "R8");
        cfg_wr(1'b0, 5, 3, 32'h0000_0000);
        probe(32'h00AB_A010, 1'b1, 1'b0, "R8");
        probe(32'h00AB_A010, 1'b1, 1'b1, "R8");
        probe(32'hC000_0044, 1'b0, 1'b0, "R8");

        // R11 write and fetch in the same cycle
        @(negedge clk);
        fetch_req = 1'b1; fetch_va = 32'h1234_4100;
        xlate_en = 1'b1; mmu_present = 1'b1; sup_mode = 1'b0;
        sb_q.push_back(model(32'h1234_4100, 1'b1, 1'b1, 1'b0, 1'b0, "R11"));
        cfg_we = 1'b1; cfg_sel_trans = 1'b1; cfg_set = 3'd6; cfg_way = 2'd0;
        cfg_wdata = 32'h0123_A003;
        bt[6][0] = 32'h0123_A003;
        @(posedge clk); #1;
        fetch_req = 1'b0; cfg_we = 1'b0;
        cfg_rd(1'b0, 2, 0, "R11");
        cfg_rd(1'b0, 2, 1, "R11");
        cfg_rd(1'b1, 6, 0, "R11");

        // R10 idle and drain
        repeat (3) @(negedge clk);
        check(rsp_valid == 1'b0, "R10", "rsp_valid while idle", {31'd0, rsp_valid}, 32'd0);
        check(sb_q.size() == 0, "R10", "responses outstanding", 32'(sb_q.size()), 32'd0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule